// File: doc/BRIEF.md
# MII Receive Delimiter and Runt Filter

This block sits behind an MII-style receive interface. On each clock it takes one 4-bit nibble and a data-valid flag from the PHY. It skips the preamble and locks onto the start-of-frame delimiter. It then pairs the nibbles that follow into bytes and presents them to a receive buffer as a byte stream, with a strobe on the first byte.

When data-valid drops, the block closes the frame with one of two strobes:
- A completion strobe, when at least the minimum number of bytes was received.
- A discard strobe, when the frame is a runt. The buffer uses it to rewind its write pointer, so the short fragment never reaches the host.

A diagnostic input lets runts complete normally instead of being discarded. A second mode input covers PHYs that send no preamble. In that mode the very first nibble of a burst is taken as the delimiter.

Top module: `mii_rx_framer`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, byte_valid_o, sof_o, eof_o and discard_o are all low.
- R2: With sfd_first_i low at the start of a burst, every nibble before the first nibble of value 4'hD is dropped, including preamble nibbles 4'h5 and any other value. That 4'hD nibble is consumed as the delimiter, and the nibbles after it are frame data.
- R3: With sfd_first_i high while the block is idle, the first nibble of a burst is consumed as the delimiter whatever its value. Every later nibble of the burst is frame data.
- R4: Each pair of data nibbles forms one byte, with the first nibble in bits 3:0 and the second in bits 7:4. The byte is on byte_o with byte_valid_o high for one cycle, in the cycle after the clock edge that sampled the second nibble. byte_valid_o is never high in two consecutive cycles.
- R5: sof_o is high together with byte_valid_o on the first byte of each frame and low on every other byte.
- R6: When a frame of at least MIN_BYTES bytes (default 64) ends, eof_o is high for exactly one cycle. That cycle follows the edge at which rx_dv_i was first sampled low, one cycle after the last byte.
- R7: When a frame of 1 to MIN_BYTES-1 bytes ends and accept_runt_i is low, discard_o pulses instead of eof_o, with the same timing as R6. A frame of exactly MIN_BYTES-1 bytes is discarded.
- R8: When accept_runt_i is high at the end of a frame of 1 to MIN_BYTES-1 bytes, eof_o pulses and discard_o stays low.
- R9: A burst in which rx_dv_i falls before a delimiter is found, or right after the delimiter with no byte completed, produces no activity on any output.
- R10: An odd trailing data nibble is dropped and does not count toward the frame length.
- R11: At most one of byte_valid_o, eof_o and discard_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_dv_i | input | 1 | Receive data valid from the PHY |
| rx_nib_i | input | 4 | Receive nibble from the PHY |
| sfd_first_i | input | 1 | First nibble of a burst is the delimiter |
| accept_runt_i | input | 1 | Let short frames complete instead of being discarded |
| byte_o | output | 8 | Assembled frame byte |
| byte_valid_o | output | 1 | byte_o holds a new byte |
| sof_o | output | 1 | Current byte is the first of the frame |
| eof_o | output | 1 | Frame completed |
| discard_o | output | 1 | Frame dropped as a runt |

## Verification
The bench targets the length boundary with frames of 63 and 64 bytes. A filter with an off-by-one compare would discard the 64-byte frame or keep the 63-byte one.

It sends preambles that contain stray nibbles and bursts that never reach a delimiter. A detector that needs a clean run of 4'h5, or that treats any nibble as data, would either lose frames or emit spurious bytes.

First-nibble mode is tried with 4'h5 and 4'hD as the leading nibble. A design that still hunts would consume a data nibble and shift every byte by half.

Frames with an odd trailing nibble, and frames that end with no complete byte, expose a design that emits a half-filled byte or sends an end strobe for an empty frame.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;

  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;
endpackage

// File: rtl/mii_rx_sfd_det.sv
module mii_rx_sfd_det
  import mii_rx_pkg::*;
#(
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_dv_i,
  input  logic [NIB_W-1:0] rx_nib_i,
  input  logic             sfd_first_i,
  output logic             data_nib_o,
  output logic             frame_end_o
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rx_dv_i) begin
          // first-nibble mode: the opening nibble is the delimiter
          if (sfd_first_i || rx_nib_i == SFD_NIB) state_d = ST_DATA;
          else                                    state_d = ST_HUNT;
        end
      end
      ST_HUNT: begin
        if (!rx_dv_i)                    state_d = ST_IDLE;
        else if (rx_nib_i == SFD_NIB)    state_d = ST_DATA;
      end
      ST_DATA: begin
        if (!rx_dv_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign data_nib_o  = (state_q == ST_DATA) &&  rx_dv_i;
  assign frame_end_o = (state_q == ST_DATA) && !rx_dv_i;
endmodule

// File: rtl/mii_rx_byte_pack.sv
module mii_rx_byte_pack
  import mii_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_nib_i,
  input  logic [NIB_W-1:0]  rx_nib_i,
  input  logic              frame_end_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              sof_o
);
  logic             phase_q;
  logic [NIB_W-1:0] low_q;
  logic             first_q;
  logic [BYTE_W-1:0] byte_q;
  logic             vld_q, sof_q;

  assign byte_done_o = data_nib_i && phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      low_q   <= '0;
      first_q <= 1'b1;
      byte_q  <= '0;
      vld_q   <= 1'b0;
      sof_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      sof_q <= 1'b0;
      if (frame_end_i) begin
        phase_q <= 1'b0;  // odd trailing nibble is dropped
        first_q <= 1'b1;
      end else if (data_nib_i) begin
        if (!phase_q) begin
          low_q   <= rx_nib_i;
          phase_q <= 1'b1;
        end else begin
          byte_q  <= {rx_nib_i, low_q};
          vld_q   <= 1'b1;
          sof_q   <= first_q;
          first_q <= 1'b0;
          phase_q <= 1'b0;
        end
      end
    end
  end

  assign byte_o       = byte_q;
  assign byte_valid_o = vld_q;
  assign sof_o        = sof_q;
endmodule

// File: rtl/mii_rx_runt_gate.sv
module mii_rx_runt_gate #(
  parameter int unsigned MIN_BYTES = 64,
  localparam int unsigned CNT_W    = $clog2(MIN_BYTES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byte_done_i,
  input  logic frame_end_i,
  input  logic accept_runt_i,
  output logic eof_o,
  output logic discard_o
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             eof_q, disc_q;
  logic             empty, short_frm;

  assign empty     = (cnt_q == '0);
  assign short_frm = (cnt_q < MIN_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      eof_q  <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      eof_q  <= 1'b0;
      disc_q <= 1'b0;
      if (frame_end_i) begin
        cnt_q  <= '0;
        eof_q  <= !empty && (!short_frm || accept_runt_i);
        disc_q <= !empty &&   short_frm && !accept_runt_i;
      end else if (byte_done_i && short_frm) begin
        cnt_q <= cnt_q + 1'b1;  // saturates at the minimum
      end
    end
  end

  assign eof_o     = eof_q;
  assign discard_o = disc_q;
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
#(
  parameter int unsigned      MIN_BYTES = 64,
  parameter logic [3:0]       SFD_NIB   = 4'hD
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_dv_i,
  input  logic [3:0] rx_nib_i,
  input  logic       sfd_first_i,
  input  logic       accept_runt_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       sof_o,
  output logic       eof_o,
  output logic       discard_o
);
  logic data_nib, frame_end, byte_done;

  mii_rx_sfd_det #(.SFD_NIB(SFD_NIB)) i_sfd_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_dv_i     (rx_dv_i),
    .rx_nib_i    (rx_nib_i),
    .sfd_first_i (sfd_first_i),
    .data_nib_o  (data_nib),
    .frame_end_o (frame_end)
  );

  mii_rx_byte_pack i_byte_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .data_nib_i   (data_nib),
    .rx_nib_i     (rx_nib_i),
    .frame_end_i  (frame_end),
    .byte_done_o  (byte_done),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .sof_o        (sof_o)
  );

  mii_rx_runt_gate #(.MIN_BYTES(MIN_BYTES)) i_runt_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .byte_done_i   (byte_done),
    .frame_end_i   (frame_end),
    .accept_runt_i (accept_runt_i),
    .eof_o         (eof_o),
    .discard_o     (discard_o)
  );
endmodule

// File: rtl/mii_rx_framer_chk.sv
module mii_rx_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_dv_i,
  input logic accept_runt_i,
  input logic byte_valid_o,
  input logic sof_o,
  input logic eof_o,
  input logic discard_o
);
  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, eof_o, discard_o}));

  p_sof_with_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> byte_valid_o);

  p_byte_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  p_byte_from_dv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_valid_o) |-> $past(rx_dv_i));

  p_end_after_dv_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_o || discard_o) |-> !$past(rx_dv_i));

  p_discard_needs_filter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> !$past(accept_runt_i));
endmodule

bind mii_rx_framer mii_rx_framer_chk i_framer_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_dv_i       (rx_dv_i),
  .accept_runt_i (accept_runt_i),
  .byte_valid_o  (byte_valid_o),
  .sof_o         (sof_o),
  .eof_o         (eof_o),
  .discard_o     (discard_o)
);

// File: tb/test_mii_rx_framer.sv
`timescale 1ns/1ps
module test_mii_rx_framer;
  localparam int MIN_BYTES = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_dv = 1'b0;
  logic [3:0] rx_nib = 4'h0;
  logic       sfd_first = 1'b0;
  logic       accept_runt = 1'b0;
  logic [7:0] byte_q;
  logic       byte_valid, sof, eof, discard;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // item: {kind[1:0], sof, data[7:0]}; kind 0 byte, 1 eof, 2 discard
  logic [10:0] exp_q[$];
  string       req_q[$];

  always #2.5 clk = ~clk;

  mii_rx_framer #(.MIN_BYTES(MIN_BYTES)) i_mii_rx_framer (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .rx_dv_i       (rx_dv),
    .rx_nib_i      (rx_nib),
    .sfd_first_i   (sfd_first),
    .accept_runt_i (accept_runt),
    .byte_o        (byte_q),
    .byte_valid_o  (byte_valid),
    .sof_o         (sof),
    .eof_o         (eof),
    .discard_o     (discard)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && (byte_valid || eof || discard)) begin
      logic [10:0] got;
      check(int'(byte_valid) + int'(eof) + int'(discard) == 1, "R11",
            {29'd0, byte_valid, eof, discard}, 32'd0);
      if (byte_valid)   got = {2'd0, sof, byte_q};
      else if (eof)     got = {2'd1, 9'd0};
      else              got = {2'd2, 9'd0};
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected output", {21'd0, got}, 32'd0);
      end else begin
        logic [10:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(got == e, r, {21'd0, got}, {21'd0, e});
      end
    end
  end

  task automatic push(input logic [10:0] item, input string req);
    exp_q.push_back(item);
    req_q.push_back(req);
  endtask

  task automatic nib(input logic [3:0] n);
    @(negedge clk);
    rx_dv  = 1'b1;
    rx_nib = n;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      rx_dv  = 1'b0;
      rx_nib = 4'h0;
    end
  endtask

  // alt=1: lead nibble used as delimiter; alt=0: pre_n preamble nibbles then 4'hD
  task automatic frame(input bit alt, input logic [3:0] lead, input int pre_n,
                       input int nbytes, input bit acc, input bit odd,
                       input logic [7:0] seed, input string req);
    @(negedge clk);
    sfd_first   = alt;
    accept_runt = acc;
    if (alt) nib(lead);
    else begin
      for (int i = 0; i < pre_n; i++) nib((i == 2) ? 4'hA : 4'h5);
      nib(4'hD);
    end
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 37);
      push({2'd0, (i == 0), b}, (i == 0) ? {req, " R4 R5"} : {req, " R4"});
      nib(b[3:0]);
      nib(b[7:4]);
    end
    if (odd) nib(4'hC);
    if (nbytes > 0) begin
      if (nbytes >= MIN_BYTES)  push({2'd1, 9'd0}, {req, " R6"});
      else if (acc)             push({2'd1, 9'd0}, {req, " R8"});
      else                      push({2'd2, 9'd0}, {req, " R7"});
    end
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({byte_valid, sof, eof, discard} == 4'b0, "R1 in reset",
          {28'd0, byte_valid, sof, eof, discard}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({byte_valid, sof, eof, discard} == 4'b0, "R1 after reset",
          {28'd0, byte_valid, sof, eof, discard}, 32'd0);

    frame(1'b0, 4'h0, 15, 64, 1'b0, 1'b0, 8'h11, "R2 64B");
    frame(1'b0, 4'h0, 7, 63, 1'b0, 1'b0, 8'h22, "R7 63B");
    frame(1'b0, 4'h0, 3, 5, 1'b0, 1'b0, 8'h33, "R7 5B");
    frame(1'b0, 4'h0, 4, 5, 1'b1, 1'b0, 8'h44, "R8 5B");
    frame(1'b0, 4'h0, 0, 1, 1'b1, 1'b0, 8'h55, "R8 1B no preamble");
    frame(1'b1, 4'h5, 0, 64, 1'b0, 1'b0, 8'h66, "R3 lead 5");
    frame(1'b1, 4'hD, 0, 10, 1'b0, 1'b0, 8'h77, "R3 lead D");
    frame(1'b0, 4'h0, 5, 64, 1'b0, 1'b1, 8'h88, "R10 64B+nib");
    frame(1'b0, 4'h0, 5, 63, 1'b0, 1'b1, 8'h99, "R10 63B+nib");
    // R9: burst with no delimiter
    @(negedge clk); sfd_first = 1'b0;
    for (int i = 0; i < 12; i++) nib((i % 3 == 2) ? 4'h7 : 4'h5);
    idle(3);
    // R9: delimiter then drop, and delimiter plus a single nibble
    frame(1'b0, 4'h0, 6, 0, 1'b0, 1'b0, 8'h00, "R9 empty");
    frame(1'b0, 4'h0, 6, 0, 1'b1, 1'b1, 8'h00, "R9 half byte");
    frame(1'b1, 4'h2, 0, 0, 1'b0, 1'b1, 8'h00, "R9 alt half");
    frame(1'b0, 4'h0, 9, 70, 1'b1, 1'b0, 8'hA5, "R6 long");
    idle(10);
    check(exp_q.size() == 0, "R6 all events seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule